// File: doc/BRIEF.md
# Mailbox command sequencer

This block is a hardware master that runs one complete command exchange with a coprocessor through a shared register mailbox. It acts for a single requester. The requester hands over a command code, a direction flag and four 32-bit argument words. The flag says whether the arguments are sent to the coprocessor or whether four result words are fetched back. The sequencer then carries out the exchange on its own and reports one error class.

The exchange runs in a fixed order:

1. Wait for the mailbox to become free.
2. Clear the status word.
3. Write the arguments, for a send.
4. Write the command word.
5. Ring the doorbell.
6. Wait for the completion interrupt, within a bounded time.
7. Validate the status, fetch the results for a receive, and acknowledge by clearing the status.

The mailbox is reached through a simple word-addressed port whose read data is valid in the same cycle as the access. Word 0 holds the command, word 1 holds the status, and words 2 to 5 hold parameters 0 to 3. The doorbell is a separate one-cycle output pulse. The poll limit and the completion timeout are parameters, counted in reads and in clock cycles.

Top module: `mbox_cmd_seq`

## Requirements
- R1: Out of reset, `busy`, `done` and `bell` are low and no mailbox access (`mb_en`) is made.
- R2: After a request is accepted, word 0 is read once per cycle until it reads zero. If POLL_LIMIT successive reads are all non-zero, the sequencer finishes with result 1 (busy, retry) and makes no write.
- R3: The first write of every issued command stores 0 to word 1 (status), ahead of any parameter or command write.
- R4: For a send (`req_send`=1), words 2..5 are written with argument words 0..3 (`req_args[32*i+:32]`) in that order. The command word then goes to word 0, and `bell` pulses in the next cycle. For a receive, no parameter word is written.
- R5: If `irq` is not seen within TIMEOUT_CYC cycles after the `bell` cycle, the result is 2 (timeout). `done` rises TIMEOUT_CYC+1 cycles after `bell`, and no acknowledge write is made.
- R6: After `irq`, a status read of 0 or of a value above 0xFF gives result 2 (timeout), with no acknowledge write.
- R7: For a receive with a valid status, words 2..5 are read into `res_args[32*i+:32]`, i=0..3.
- R8: A valid status (1..0xFF) is acknowledged by a final write of 0 to word 1.
- R9: Valid status maps to `result` as follows. 0xF1 gives 3 (invalid), 0xF2 gives 4 (unsupported), 0xF3 gives 5 (no map), 0xF4 gives 6 (map already set), 0xFF gives 7 (I/O error). Any other valid value, 0xF0 included, gives 0 (success).
- R10: `busy` is high from the cycle after acceptance until the end of the exchange. A `req_valid` while busy is ignored.
- R11: `done` is a one-cycle pulse, and `result` is valid while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Start request; taken only while idle |
| req_cmd | input | 32 | Command code |
| req_send | input | 1 | 1: write arguments; 0: read results |
| req_args | input | 128 | Four argument words, word i at bits 32*i+:32 |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 3 | Error class, valid with done |
| res_args | output | 128 | Result words of the last receive |
| mb_en | output | 1 | Mailbox access strobe |
| mb_we | output | 1 | Mailbox write enable |
| mb_addr | output | 3 | Mailbox word index |
| mb_wdata | output | 32 | Mailbox write data |
| mb_rdata | input | 32 | Mailbox read data, same cycle |
| bell | output | 1 | Doorbell pulse to the coprocessor |
| irq | input | 1 | Completion interrupt from the coprocessor |

## Verification
A wrong state sequence shows at once on the mailbox port. Each access is recorded as an address and data trace and compared word for word with the order the requirements dictate. A miscounting poll or timeout counter shifts the cycle at which `done` rises, so both windows are measured exactly at their boundaries: one read short of the poll limit and exactly at it, and the cycle distance from `bell` to `done`. A fault in the status check or the result mapping appears in `result` and in whether the acknowledge write happens. For that reason every status value from 0 to 0xFF, plus one value above 0xFF, is swept.

// File: rtl/mbox_cmd_seq.sv
module mbox_cmd_seq #(
  parameter int POLL_LIMIT  = 10000,
  parameter int TIMEOUT_CYC = 15000000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  input  logic [31:0]  req_cmd,
  input  logic         req_send,
  input  logic [127:0] req_args,
  output logic         busy,
  output logic         done,
  output logic [2:0]   result,
  output logic [127:0] res_args,
  output logic         mb_en,
  output logic         mb_we,
  output logic [2:0]   mb_addr,
  output logic [31:0]  mb_wdata,
  input  logic [31:0]  mb_rdata,
  output logic         bell,
  input  logic         irq
);
  localparam int PW = $clog2(POLL_LIMIT + 1);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [2:0] A_CMD = 3'd0, A_STAT = 3'd1, A_PAR = 3'd2;
  localparam logic [2:0] RES_OK = 3'd0, RES_BUSY = 3'd1, RES_TMO = 3'd2;

  typedef enum logic [3:0] {
    S_IDLE, S_POLL, S_CLR, S_WPAR, S_WCMD, S_BELL, S_WAIT, S_RDST, S_RPAR, S_ACK
  } st_t;

  st_t            st;
  logic [31:0]    cmd_q;
  logic           send_q;
  logic [127:0]   args_q;
  logic [1:0]     idx;
  logic [PW-1:0]  pcnt;
  logic [TW-1:0]  tcnt;
  logic [7:0]     stat_q;

  function automatic logic [2:0] map_status(input logic [7:0] s);
    case (s)
      8'hF1:   return 3'd3;
      8'hF2:   return 3'd4;
      8'hF3:   return 3'd5;
      8'hF4:   return 3'd6;
      8'hFF:   return 3'd7;
      default: return RES_OK;
    endcase
  endfunction

  assign busy = (st != S_IDLE);
  assign bell = (st == S_BELL);

  always_comb begin
    mb_en    = 1'b0;
    mb_we    = 1'b0;
    mb_addr  = A_CMD;
    mb_wdata = '0;
    case (st)
      S_POLL: mb_en = 1'b1;
      S_CLR:  begin mb_en = 1'b1; mb_we = 1'b1; mb_addr = A_STAT; end
      S_WPAR: begin
        mb_en = 1'b1; mb_we = 1'b1; mb_addr = A_PAR + 3'(idx);
        mb_wdata = args_q[32*idx +: 32];
      end
      S_WCMD: begin mb_en = 1'b1; mb_we = 1'b1; mb_wdata = cmd_q; end
      S_RDST: begin mb_en = 1'b1; mb_addr = A_STAT; end
      S_RPAR: begin mb_en = 1'b1; mb_addr = A_PAR + 3'(idx); end
      S_ACK:  begin mb_en = 1'b1; mb_we = 1'b1; mb_addr = A_STAT; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cmd_q    <= '0;
      send_q   <= 1'b0;
      args_q   <= '0;
      idx      <= '0;
      pcnt     <= '0;
      tcnt     <= '0;
      stat_q   <= '0;
      done     <= 1'b0;
      result   <= RES_OK;
      res_args <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          cmd_q  <= req_cmd;
          send_q <= req_send;
          args_q <= req_args;
          pcnt   <= '0;
          tcnt   <= '0;
          st     <= S_POLL;
        end
        S_POLL: begin
          if (mb_rdata == 32'd0) st <= S_CLR;
          else if (pcnt == PW'(POLL_LIMIT - 1)) begin
            st <= S_IDLE; done <= 1'b1; result <= RES_BUSY;
          end else pcnt <= pcnt + 1'b1;
        end
        S_CLR: begin
          idx <= '0;
          st  <= send_q ? S_WPAR : S_WCMD;
        end
        S_WPAR: begin
          idx <= idx + 1'b1;
          if (idx == 2'd3) st <= S_WCMD;
        end
        S_WCMD: st <= S_BELL;
        S_BELL: begin
          tcnt <= '0;
          st   <= S_WAIT;
        end
        S_WAIT: begin
          if (irq) st <= S_RDST;
          else if (tcnt == TW'(TIMEOUT_CYC - 1)) begin
            st <= S_IDLE; done <= 1'b1; result <= RES_TMO;
          end else tcnt <= tcnt + 1'b1;
        end
        S_RDST: begin
          if (mb_rdata == 32'd0 || mb_rdata[31:8] != 24'd0) begin
            st <= S_IDLE; done <= 1'b1; result <= RES_TMO;
          end else begin
            stat_q <= mb_rdata[7:0];
            idx    <= '0;
            st     <= send_q ? S_ACK : S_RPAR;
          end
        end
        S_RPAR: begin
          res_args[32*idx +: 32] <= mb_rdata;
          idx <= idx + 1'b1;
          if (idx == 2'd3) st <= S_ACK;
        end
        S_ACK: begin
          st <= S_IDLE; done <= 1'b1; result <= map_status(stat_q);
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mb_en && !bell)); // R10
  AST_BELL_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    bell |-> $past(mb_en && mb_we && mb_addr == A_CMD)); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt < PW'(POLL_LIMIT)); // R2
  AST_TIMEOUT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tcnt < TW'(TIMEOUT_CYC)); // R5
  AST_CLEAR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (mb_en && mb_we && $past(!mb_we || !mb_en) && $past(mb_addr == A_CMD) && $past(mb_en))
      |-> mb_addr == A_STAT); // R3
endmodule

// File: tb/mbox_cmd_seq_tb.sv
module mbox_cmd_seq_tb;
  localparam int PL = 4;
  localparam int TO = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [31:0] req_cmd = '0;
  logic req_send = 1'b0;
  logic [127:0] req_args = '0;
  logic busy, done, mb_en, mb_we, bell;
  logic [2:0] result, mb_addr;
  logic [127:0] res_args;
  logic [31:0] mb_wdata, mb_rdata;
  logic irq;

  always #10 clk = ~clk;

  mbox_cmd_seq #(.POLL_LIMIT(PL), .TIMEOUT_CYC(TO)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_send(req_send), .req_args(req_args), .busy(busy), .done(done),
    .result(result), .res_args(res_args), .mb_en(mb_en), .mb_we(mb_we),
    .mb_addr(mb_addr), .mb_wdata(mb_wdata), .mb_rdata(mb_rdata),
    .bell(bell), .irq(irq));

  // coprocessor and mailbox model
  logic [31:0] mb [0:5];
  int tr_a [0:15];
  logic [31:0] tr_d [0:15];
  int tr_n, cmd_reads, busy_left, fwcnt, cyc, bell_at, done_at;
  int busy_init, fw_delay;
  logic [31:0] fw_status;
  logic fw_irq_en;
  logic [31:0] fw_ret [0:3];

  assign mb_rdata = (mb_addr == 3'd0) ? ((busy_left > 0) ? 32'h55 : mb[0]) :
                    (mb_addr <= 3'd5) ? mb[mb_addr] : 32'd0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 6; i++) mb[i] <= '0;
      tr_n <= 0; cmd_reads <= 0; busy_left <= 0; fwcnt <= 0; cyc <= 0;
      irq <= 1'b0; bell_at <= 0; done_at <= 0;
    end else begin
      cyc <= cyc + 1;
      irq <= 1'b0;
      if (done) done_at <= cyc;
      if (req_valid && !busy) begin
        tr_n <= 0; cmd_reads <= 0; busy_left <= busy_init; fwcnt <= 0; mb[0] <= '0;
      end else begin
        if (mb_en && mb_we) begin
          mb[mb_addr] <= mb_wdata;
          tr_a[tr_n] <= int'(mb_addr); tr_d[tr_n] <= mb_wdata; tr_n <= tr_n + 1;
        end
        if (mb_en && !mb_we && mb_addr == 3'd0) begin
          cmd_reads <= cmd_reads + 1;
          if (busy_left > 0) busy_left <= busy_left - 1;
        end
        if (bell) begin
          tr_a[tr_n] <= 7; tr_d[tr_n] <= '0; tr_n <= tr_n + 1;
          bell_at <= cyc; fwcnt <= fw_delay;
        end else if (fwcnt != 0) begin
          fwcnt <= fwcnt - 1;
          if (fwcnt == 1) begin
            mb[1] <= fw_status; mb[0] <= '0;
            for (int i = 0; i < 4; i++) mb[2+i] <= fw_ret[i];
            irq <= fw_irq_en;
          end
        end
      end
    end
  end

  int checks = 0, fails = 0;

  task automatic chk(input logic ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_map(input logic [31:0] s);
    if (s == 0 || s > 32'hFF) return 3'd2;
    case (s[7:0])
      8'hF1: return 3'd3;
      8'hF2: return 3'd4;
      8'hF3: return 3'd5;
      8'hF4: return 3'd6;
      8'hFF: return 3'd7;
      default: return 3'd0;
    endcase
  endfunction

  logic [2:0] got_res;

  task automatic run(input logic [31:0] cmd, input logic snd, input logic [127:0] args,
                     input int binit, input int dly, input logic [31:0] st, input logic ien);
    int n;
    busy_init = binit; fw_delay = dly; fw_status = st; fw_irq_en = ien;
    @(negedge clk);
    req_cmd = cmd; req_send = snd; req_args = args; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!done && n < 500) begin @(negedge clk); n++; end
    if (n >= 500) chk(1'b0, "watchdog", 0, 1);
    got_res = result;
    @(negedge clk);
    chk(!done, "R11 done pulse width", done, 0);
  endtask

  logic [127:0] A;
  initial begin
    A = {32'hDDDD0003, 32'hCCCC0002, 32'hBBBB0001, 32'hAAAA0000};
    fw_ret[0] = 32'h11; fw_ret[1] = 32'h22; fw_ret[2] = 32'h33; fw_ret[3] = 32'h44;
    busy_init = 0; fw_delay = 3; fw_status = 32'hF0; fw_irq_en = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mb_en && !bell, "R1 reset outputs", {busy, done, mb_en, bell}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !mb_en && !bell, "R1 idle after reset", {busy, mb_en, bell}, 0);

    // send command, full trace
    run(32'h41, 1'b1, A, 0, 3, 32'hF0, 1'b1);
    chk(got_res == 3'd0, "R9 success 0xF0", got_res, 0);
    chk(tr_n == 8, "R4 send trace length", tr_n, 8);
    begin
      int ea [0:7] = '{1, 2, 3, 4, 5, 0, 7, 1};
      logic [31:0] ed [0:7];
      ed[0] = 0; ed[5] = 32'h41; ed[6] = 0; ed[7] = 0;
      for (int i = 0; i < 4; i++) ed[1+i] = A[32*i +: 32];
      chk(tr_a[0] == 1 && tr_d[0] == 0, "R3 status cleared first", tr_d[0], 0);
      for (int i = 1; i < 7; i++)
        chk(tr_a[i] == ea[i] && tr_d[i] == ed[i], "R4 send order", {tr_a[i], tr_d[i]}, {ea[i], ed[i]});
      chk(tr_a[7] == 1 && tr_d[7] == 0, "R8 acknowledge write", {tr_a[7], tr_d[7]}, {32'd1, 32'd0});
    end

    // receive command
    run(32'h40, 1'b0, '0, 0, 5, 32'hF0, 1'b1);
    chk(got_res == 3'd0, "R9 receive success", got_res, 0);
    chk(res_args == {fw_ret[3], fw_ret[2], fw_ret[1], fw_ret[0]}, "R7 result words", res_args,
        {fw_ret[3], fw_ret[2], fw_ret[1], fw_ret[0]});
    chk(tr_n == 4 && tr_a[0] == 1 && tr_a[1] == 0 && tr_a[2] == 7 && tr_a[3] == 1,
        "R4 receive writes no params", tr_n, 4);
    chk(tr_d[1] == 32'h40, "R4 receive command word", tr_d[1], 32'h40);

    // poll limit boundaries
    run(32'h41, 1'b1, A, PL, 3, 32'hF0, 1'b1);
    chk(got_res == 3'd1, "R2 busy after limit", got_res, 1);
    chk(cmd_reads == PL, "R2 read count at limit", cmd_reads, PL);
    chk(tr_n == 0, "R2 no write when busy", tr_n, 0);
    run(32'h41, 1'b1, A, PL - 1, 3, 32'hF0, 1'b1);
    chk(got_res == 3'd0, "R2 success one below limit", got_res, 0);
    chk(cmd_reads == PL, "R2 reads one below limit", cmd_reads, PL);

    // timeout: no interrupt, and interrupt too late
    run(32'h40, 1'b0, '0, 0, 3, 32'hF0, 1'b0);
    chk(got_res == 3'd2, "R5 timeout result", got_res, 2);
    chk(done_at - bell_at == TO + 1, "R5 timeout cycle", done_at - bell_at, TO + 1);
    chk(tr_n == 3, "R5 no acknowledge", tr_n, 3);
    run(32'h40, 1'b0, '0, 0, TO + 10, 32'hF0, 1'b1);
    chk(got_res == 3'd2, "R5 late interrupt timeout", got_res, 2);
    repeat (15) @(negedge clk);
    run(32'h40, 1'b0, '0, 0, TO - 1, 32'hF0, 1'b1);
    chk(got_res == 3'd0, "R5 interrupt just in time", got_res, 0);

    // invalid status values
    run(32'h40, 1'b0, '0, 0, 3, 32'h0, 1'b1);
    chk(got_res == 3'd2 && tr_n == 3, "R6 status zero", {got_res, tr_n}, {3'd2, 32'd3});
    run(32'h40, 1'b1, A, 0, 3, 32'h100, 1'b1);
    chk(got_res == 3'd2 && tr_n == 7, "R6 status above 0xFF", {got_res, tr_n}, {3'd2, 32'd7});

    // sweep of all valid status codes
    for (int s = 1; s < 256; s++) begin
      run(32'h40, 1'b0, '0, 0, 2, 32'(s), 1'b1);
      chk(got_res == exp_map(32'(s)), "R9 status map", got_res, exp_map(32'(s)));
      chk(tr_n == 4 && tr_a[3] == 1 && tr_d[3] == 0, "R8 ack per status", tr_n, 4);
    end

    // request while busy is ignored
    busy_init = 0; fw_delay = 6; fw_status = 32'hF4; fw_irq_en = 1'b1;
    @(negedge clk);
    req_cmd = 32'h31; req_send = 1'b1; req_args = A; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy, "R10 busy after accept", busy, 1);
    repeat (3) @(negedge clk);
    req_cmd = 32'h99; req_send = 1'b0; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    begin
      int n = 0;
      while (!done && n < 500) begin @(negedge clk); n++; end
    end
    chk(result == 3'd6, "R10 first request result", result, 6);
    chk(tr_d[5] == 32'h31 && tr_n == 8, "R10 second request ignored", tr_d[5], 32'h31);
    @(negedge clk);
    chk(!busy && !mb_en, "R10 idle after finish", {busy, mb_en}, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule